// File: doc/BRIEF.md
# Relative Jump Fetch Unit

This block keeps the instruction pointer for a byte-addressed instruction memory and reads one byte per cycle whenever the memory marks its byte as ready. Two unconditional relative jump opcodes are recognised. The short jump carries a single signed offset byte. The near jump carries a signed 16-bit offset sent as two bytes, least significant byte first. Once the last offset byte has been consumed, the offset is sign-extended to the pointer width and added to the address of the byte that follows the jump. Fetch then continues at that target.

Each instruction start is reported with its address for tracing. Every byte that is not part of a jump is passed to the execute stage together with its address, one item per byte. The execute stage is responsible for grouping those bytes into longer instructions. Offset bytes are consumed without being reported, even when their values match a jump opcode.

Top module: `rel_jump_fetch`

## Requirements
- R1: While reset is asserted and afterwards, until the first ready byte arrives, `fetch_addr` equals `RESET_ADDR` (default 0) and neither strobe is raised.
- R2: A byte is consumed only in a cycle where `fetch_ready` is 1. While `fetch_ready` is 0 the pointer holds and no strobe is raised.
- R3: A consumed byte at an instruction start that is neither 0xEB nor 0xE9 raises `exec_stb` with `exec_byte` equal to that byte and `exec_addr` equal to its address. The pointer then advances by one.
- R4: Opcode 0xEB consumes exactly one further byte, read as a signed 8-bit offset. The next instruction starts at A+2+offset, where A is the opcode address.
- R5: Opcode 0xE9 consumes two further bytes, low byte first, read as a signed 16-bit offset. The next instruction starts at A+3+offset.
- R6: Both offsets are sign-extended to the pointer width, so negative offsets move backward and the sum wraps modulo 2^AW.
- R7: Offset bytes never raise `start_stb` or `exec_stb`, even when they equal 0xEB or 0xE9.
- R8: `start_stb` is raised on the first byte of every instruction, including jumps, with `start_addr` equal to that byte's address. A jump opcode never raises `exec_stb`.
- R9: A stall (`fetch_ready` low) between the opcode and offset bytes of a jump loses no collected offset byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_addr | output | AW | Address of the byte being fetched |
| fetch_byte | input | 8 | Byte at `fetch_addr` |
| fetch_ready | input | 1 | `fetch_byte` is valid this cycle and is consumed |
| start_stb | output | 1 | First byte of an instruction consumed this cycle |
| start_addr | output | AW | Address of that instruction start |
| exec_stb | output | 1 | Non-jump byte handed to the execute stage |
| exec_byte | output | 8 | Byte handed to the execute stage |
| exec_addr | output | AW | Address of the byte handed to the execute stage |

## Verification
Three kinds of internal fault would show at the ports. A wrong sequencer state makes an offset byte appear as an instruction start, or makes a jump land one or two bytes away from its target. A lost low offset byte or a bad sign extension puts the next `start_addr` at a clearly wrong address. Each of these faults shows on the very next instruction start after the jump. Scenarios include forward and backward offsets, wrap-around through address zero, offset bytes that equal jump opcodes, and random stalls inside jumps, so each fault reaches an address comparison within a few cycles.

// File: rtl/rjf_pkg.sv
package rjf_pkg;
  typedef enum logic [1:0] {
    ST_OPC   = 2'd0,
    ST_OFF8  = 2'd1,
    ST_OFFLO = 2'd2,
    ST_OFFHI = 2'd3
  } rjf_state_e;

  localparam logic [7:0] OP_JMP_SHORT = 8'hEB;
  localparam logic [7:0] OP_JMP_NEAR  = 8'hE9;
endpackage

// File: rtl/rjf_decode.sv
module rjf_decode
  import rjf_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       is_short_o,
  output logic       is_near_o
);
  always_comb begin
    is_short_o = (byte_i == OP_JMP_SHORT);
    is_near_o  = (byte_i == OP_JMP_NEAR);
  end
endmodule

// File: rtl/rjf_seq.sv
module rjf_seq
  import rjf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv_i,
  input  logic [7:0]  byte_i,
  input  logic        is_short_i,
  input  logic        is_near_i,
  output logic        at_opc_o,
  output logic        jump_fire_o,
  output logic [15:0] off16_o
);
  rjf_state_e st_q, st_d;
  logic [7:0] lo_q, lo_d;
  logic       lo_en;

  // next-state logic
  always_comb begin
    st_d  = st_q;
    lo_en = adv_i && (st_q == ST_OFFLO);
    lo_d  = byte_i;
    if (adv_i) begin
      unique case (st_q)
        ST_OPC: begin
          if (is_short_i)     st_d = ST_OFF8;
          else if (is_near_i) st_d = ST_OFFLO;
        end
        ST_OFF8:  st_d = ST_OPC;
        ST_OFFLO: st_d = ST_OFFHI;
        ST_OFFHI: st_d = ST_OPC;
        default:  st_d = ST_OPC;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OPC;
      lo_q <= '0;
    end else begin
      st_q <= st_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  always_comb begin
    at_opc_o    = (st_q == ST_OPC);
    jump_fire_o = adv_i && ((st_q == ST_OFF8) || (st_q == ST_OFFHI));
    off16_o     = (st_q == ST_OFF8) ? {{8{byte_i[7]}}, byte_i} : {byte_i, lo_q};
  end

  // R4: a consumed short opcode is always followed by exactly one offset slot
  p_short_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPC && adv_i && is_short_i) |=> (st_q == ST_OFF8));
  // R5: the low offset byte of a near jump always leads to the high byte slot
  p_near_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFFLO && adv_i) |=> (st_q == ST_OFFHI && lo_q == $past(byte_i)));
  // R9: a stall keeps both the sequencer position and the collected low byte
  p_stall_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> ($stable(st_q) && $stable(lo_q)));
endmodule

// File: rtl/rjf_ptr.sv
module rjf_ptr #(
  parameter int unsigned    AW         = 32,
  parameter logic [AW-1:0]  RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          jump_fire_i,
  input  logic [15:0]   off16_i,
  output logic [AW-1:0] ptr_o
);
  localparam int unsigned EXT_W = (AW > 16) ? AW - 16 : 1;

  logic [AW-1:0] ptr_q, ptr_d, seq_next, off_ext;

  generate
    if (AW > 16) begin : g_ext
      assign off_ext = {{EXT_W{off16_i[15]}}, off16_i};
    end else begin : g_trunc
      assign off_ext = off16_i[AW-1:0];
    end
  endgenerate

  // next-pointer logic
  always_comb begin
    seq_next = ptr_q + AW'(1);
    ptr_d    = ptr_q;
    if (adv_i) ptr_d = jump_fire_i ? (seq_next + off_ext) : seq_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= RESET_ADDR;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R2: pointer frozen while the memory is not ready
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(ptr_q));
  // R3: a plain consumed byte steps the pointer by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !jump_fire_i) |=> (ptr_q == $past(ptr_q) + AW'(1)));
endmodule

// File: rtl/rel_jump_fetch.sv
module rel_jump_fetch
  import rjf_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] fetch_addr,
  input  logic [7:0]    fetch_byte,
  input  logic          fetch_ready,
  output logic          start_stb,
  output logic [AW-1:0] start_addr,
  output logic          exec_stb,
  output logic [7:0]    exec_byte,
  output logic [AW-1:0] exec_addr
);
  logic        is_short, is_near, at_opc, jump_fire;
  logic [15:0] off16;
  logic [AW-1:0] ptr;

  rjf_decode u_decode (
    .byte_i     (fetch_byte),
    .is_short_o (is_short),
    .is_near_o  (is_near)
  );

  rjf_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (fetch_ready),
    .byte_i      (fetch_byte),
    .is_short_i  (is_short),
    .is_near_i   (is_near),
    .at_opc_o    (at_opc),
    .jump_fire_o (jump_fire),
    .off16_o     (off16)
  );

  rjf_ptr #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (fetch_ready),
    .jump_fire_i (jump_fire),
    .off16_i     (off16),
    .ptr_o       (ptr)
  );

  always_comb begin
    fetch_addr = ptr;
    start_stb  = at_opc && fetch_ready;
    start_addr = ptr;
    exec_stb   = start_stb && !is_short && !is_near;
    exec_byte  = fetch_byte;
    exec_addr  = ptr;
  end

  // R7: the cycle after a consumed jump opcode is never an instruction start
  p_no_start_in_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb && (fetch_byte == OP_JMP_SHORT || fetch_byte == OP_JMP_NEAR)) |=> !start_stb);
  // R8: execute items only ever coincide with an instruction start
  p_exec_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> (start_stb && exec_addr == start_addr));
  // R4: a short jump lands at opcode address + 2 + signed offset
  p_short_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb && fetch_byte == OP_JMP_SHORT) |=> ##1
      (!$past(fetch_ready) || fetch_addr ==
       $past(fetch_addr) + AW'(1) + {{(AW-8){$past(fetch_byte[7])}}, $past(fetch_byte)}) || !$past(fetch_ready));
endmodule

// File: tb/rel_jump_fetch_tb.sv
module rel_jump_fetch_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] fetch_addr;
  logic [7:0]    fetch_byte;
  logic          fetch_ready;
  logic          start_stb, exec_stb;
  logic [AW-1:0] start_addr, exec_addr;
  logic [7:0]    exec_byte;

  always #4 clk = ~clk;  // 125 MHz

  rel_jump_fetch #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_byte(fetch_byte),
    .fetch_ready(fetch_ready), .start_stb(start_stb), .start_addr(start_addr),
    .exec_stb(exec_stb), .exec_byte(exec_byte), .exec_addr(exec_addr)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          is_exec;
    logic [7:0]    b;
    string         req;
  } exp_t;

  exp_t         q[$];
  logic [7:0]   mem [logic [31:0]];
  int           checks = 0, errors = 0;
  logic         run_en = 1'b0, mon_en = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;

  function automatic logic [7:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h90;
  endfunction

  task automatic put(input logic [31:0] a, input logic [7:0] bytes[$]);
    foreach (bytes[i]) mem[a + 32'(i)] = bytes[i];
  endtask

  task automatic expect_item(input logic [31:0] a, input logic ex, input logic [7:0] b, input string r);
    exp_t e;
    e.addr = a; e.is_exec = ex; e.b = b; e.req = r;
    q.push_back(e);
  endtask

  // driver: inputs change on the falling edge only
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fetch_ready <= run_en && (lfsr[0] | lfsr[3]);
    fetch_byte  <= rd(fetch_addr);
  end

  // monitor: scoreboard pops on every instruction start
  always @(negedge clk) begin
    #2;
    if (mon_en && start_stb && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (start_addr !== e.addr || exec_stb !== e.is_exec ||
          (e.is_exec && (exec_byte !== e.b || exec_addr !== e.addr))) begin
        errors++;
        $display("FAIL %s: start_addr=%h exec=%b byte=%h expected addr=%h exec=%b byte=%h",
                 e.req, start_addr, exec_stb, exec_byte, e.addr, e.is_exec, e.b);
      end
    end
  end

  task automatic run_case(input string name);
    int n;
    run_en = 1'b0; mon_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    checks++;  // R1 / R2: reset value and hold while not ready
    if (fetch_addr !== '0 || start_stb !== 1'b0 || exec_stb !== 1'b0) begin
      errors++;
      $display("FAIL R1 %s: fetch_addr=%h start=%b exec=%b expected 0 0 0",
               name, fetch_addr, start_stb, exec_stb);
    end
    mon_en = 1'b1; run_en = 1'b1;
    n = 0;
    while (q.size() > 0 && n < 400) begin
      @(negedge clk); n++;
    end
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d items left, expected 0", name, q.size());
    end
    repeat (4) @(negedge clk);
    mon_en = 1'b0; run_en = 1'b0;
    repeat (2) @(negedge clk);
    mem.delete();
    q.delete();
  endtask

  initial begin
    rst_n = 1'b0; fetch_ready = 1'b0; fetch_byte = '0;

    // R3, R4, R8: short forward jump over dead bytes
    put(0, '{8'h05, 8'hEB, 8'h05, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h22, 8'h33, 8'hEB, 8'hFE});
    expect_item(0, 1, 8'h05, "R3");
    expect_item(1, 0, 0, "R8");
    expect_item(8, 1, 8'h22, "R4");
    expect_item(9, 1, 8'h33, "R3");
    expect_item(10, 0, 0, "R8");
    run_case("short");

    // R5, R9: near forward jump under random stalls
    put(0, '{8'h05, 8'hE9, 8'h05, 8'h00, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h22, 8'hEB, 8'hFE});
    expect_item(0, 1, 8'h05, "R3");
    expect_item(1, 0, 0, "R5");
    expect_item(9, 1, 8'h22, "R5");
    expect_item(10, 0, 0, "R9");
    run_case("near");

    // R6: backward short across zero, then near jump wrapping forward
    put(0, '{8'hEB, 8'hF0});
    put(32'hFFFF_FFF2, '{8'h44, 8'hE9, 8'h2A, 8'h00});
    put(32'h20, '{8'h55, 8'hEB, 8'hFE});
    expect_item(0, 0, 0, "R6");
    expect_item(32'hFFFF_FFF2, 1, 8'h44, "R6");
    expect_item(32'hFFFF_FFF3, 0, 0, "R6");
    expect_item(32'h20, 1, 8'h55, "R6");
    run_case("wrap");

    // R6: 16-bit backward offset uses its sign bit
    put(0, '{8'hE9, 8'h00, 8'h02});
    put(32'h203, '{8'hE9, 8'h7A, 8'hFF});
    put(32'h180, '{8'h66, 8'hEB, 8'hFE});
    expect_item(0, 0, 0, "R5");
    expect_item(32'h203, 0, 0, "R6");
    expect_item(32'h180, 1, 8'h66, "R6");
    run_case("near_back");

    // R7: offset bytes equal to jump opcodes are not opcodes
    put(0, '{8'hEB, 8'hEB});
    put(32'hFFFF_FFED, '{8'hE9, 8'hE9, 8'h00});
    put(32'hD9, '{8'h77, 8'hEB, 8'hFE});
    expect_item(0, 0, 0, "R7");
    expect_item(32'hFFFF_FFED, 0, 0, "R7");
    expect_item(32'hD9, 1, 8'h77, "R7");
    run_case("opcode_offsets");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule